// File: doc/BRIEF.md
# Up-Counting Event Timer with Overflow Reload

This block is a general-purpose event timer built around an up-counter. Software sets a delay of N cycles by writing the counter with all-ones minus N and then setting the run bit. The counter advances by one on every clock. When it steps past all-ones it raises an overflow flag, and that flag drives the interrupt line when the interrupt enable is set. With the reload bit set, the counter takes the reload value at every overflow and keeps running, so the block acts as a periodic tick. With the reload bit clear, it stops after the first overflow.

Writes to the control, reload and counter registers can be posted. In that case the block captures the write on the bus side and applies it to the counting logic a fixed number of cycles later (`SYNC_LAT`), which models the delay of crossing into the functional clock domain. A pending bit for each of these registers shows the write is still in flight. With `SYNC_LAT` set to 0, writes apply on the capture edge. The status and enable registers always act at once.

Top module: `tmr_up_top`

## Requirements
- R1: After reset every register reads zero, no write is pending, and `irq` is low.
- R2: While the run bit is set and the counter is not all-ones, the counter increases by one each clock. A read at address 2 returns the current count.
- R3: When the counter is all-ones and running, the next edge wraps it and sets overflow status (address 3, bit 0). Starting from all-ones minus N, the flag is visible N+1 edges after the start is applied.
- R4: With the reload bit (address 0, bit 1) clear, the overflow edge leaves the counter at zero and clears the run bit (address 0, bit 0). The counter then stays at zero.
- R5: With the reload bit set, every overflow edge copies the reload register (address 1) into the counter and counting continues.
- R6: Writing a one to status bit 0 clears it. Writing a zero leaves it set. When a clearing write lands on the same edge as a new overflow, the flag stays set.
- R7: `irq` is high exactly when overflow status is set and the enable bit (address 4, bit 0) is set. An overflow with enable clear leaves `irq` low.
- R8: A write to address 0, 1 or 2 takes effect `SYNC_LAT` edges after the edge that captures it. Until then, the pending register (address 5) shows bit 0, 1 or 2 respectively for that register.
- R9: Writing address 0 with the run bit clear stops the counter once the write applies. The count then holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for bus and counting logic |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, captured on the rising edge |
| bus_addr | input | 3 | Register select for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Overflow interrupt, level |

## Verification
Each result has a fixed cycle in which it is due. A posted write becomes readable exactly `SYNC_LAT` edges after its capture edge. A started count of all-ones minus N raises the flag N+1 edges after the start applies. Status and enable writes act on the capture edge itself. The driver works out these edge numbers from a free-running cycle count and queues the expected `irq` level for the cycle just before and the cycle exactly at each overflow. The monitor compares those entries at the falling edge of the due cycle. Register reads are sampled at the same falling-edge points, one cycle before and exactly at each posted write's apply edge. A late result and an early result therefore both fail.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int CNT_W  = 32;
    localparam int ADDR_W = 3;
    localparam int N_POST = 3;   // posted registers: control, reload, counter

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL  = 3'd0,
        A_LOAD  = 3'd1,
        A_COUNT = 3'd2,
        A_STAT  = 3'd3,
        A_IEN   = 3'd4,
        A_PEND  = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic             run;
        logic             reload;
        logic [CNT_W-1:0] load;
        logic [CNT_W-1:0] count;
        logic             ovf;
    } core_state_t;

endpackage

// File: rtl/tmr_wr_sync.sv
module tmr_wr_sync #(
    parameter int W   = 32,
    parameter int LAT = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_in,
    input  logic [W-1:0] wdata_in,
    output logic         apply,
    output logic [W-1:0] apply_data,
    output logic         pending
);

    generate
        if (LAT == 0) begin : g_direct
            assign apply      = wr_in;
            assign apply_data = wdata_in;
            assign pending    = 1'b0;
        end else begin : g_posted
            logic [LAT-1:0]        vld_d, vld_q;
            logic [LAT-1:0][W-1:0] dat_d, dat_q;

            always_comb begin
                vld_d[0] = wr_in;
                dat_d[0] = wdata_in;
                for (int i = 1; i < LAT; i++) begin
                    vld_d[i] = vld_q[i-1];
                    dat_d[i] = dat_q[i-1];
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_q <= '0;
                    dat_q <= '0;
                end else begin
                    vld_q <= vld_d;
                    dat_q <= dat_d;
                end
            end

            assign apply      = vld_q[LAT-1];
            assign apply_data = dat_q[LAT-1];
            assign pending    = |vld_q;

            // R8: a captured write is visible as pending on the next cycle
            assert_pend_after_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
                wr_in |=> pending);
        end
    endgenerate

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_apply,
    input  logic             ctrl_run,
    input  logic             ctrl_reload,
    input  logic             load_apply,
    input  logic [CNT_W-1:0] load_val,
    input  logic             cnt_apply,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             ovf_clr,
    output logic             run,
    output logic             reload,
    output logic [CNT_W-1:0] load,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);

    localparam logic [CNT_W-1:0] ONES = {CNT_W{1'b1}};

    core_state_t d, q;
    logic        wrap;

    always_comb begin
        d    = q;
        wrap = q.run && (q.count == ONES);
        if (q.run) begin
            if (wrap) begin
                if (q.reload) begin
                    d.count = q.load;
                end else begin
                    d.count = '0;
                    d.run   = 1'b0;
                end
            end else begin
                d.count = q.count + 1'b1;
            end
        end
        if (load_apply) d.load  = load_val;
        if (cnt_apply)  d.count = cnt_val;
        if (ctrl_apply) begin
            d.run    = ctrl_run;
            d.reload = ctrl_reload;
        end
        if (wrap)         d.ovf = 1'b1;
        else if (ovf_clr) d.ovf = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign run    = q.run;
    assign reload = q.reload;
    assign load   = q.load;
    assign count  = q.count;
    assign ovf    = q.ovf;

    assert_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.run && q.count != ONES && !cnt_apply) |=> (q.count == $past(q.count) + 1'b1));

    assert_wrap_sets_ovf_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.run && q.count == ONES) |=> q.ovf);

    assert_oneshot_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.run && q.count == ONES && !q.reload && !cnt_apply && !ctrl_apply)
        |=> (!q.run && q.count == '0));

    assert_reload_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.run && q.count == ONES && q.reload && !cnt_apply) |=> (q.count == $past(q.load)));

    assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_clr && !(q.run && q.count == ONES)) |=> !q.ovf);

    assert_stop_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.run && !cnt_apply) |=> $stable(q.count));

endmodule

// File: rtl/tmr_up_top.sv
module tmr_up_top
    import tmr_pkg::*;
#(
    parameter int SYNC_LAT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq
);

    logic [N_POST-1:0]            sel_wr;
    logic [N_POST-1:0]            apply;
    logic [N_POST-1:0]            pend;
    logic [N_POST-1:0][CNT_W-1:0] apply_data;

    // index i serves the register at address i (control, reload, counter)
    genvar gi;
    generate
        for (gi = 0; gi < N_POST; gi++) begin : g_sync
            assign sel_wr[gi] = bus_wr && (bus_addr == ADDR_W'(gi));
            tmr_wr_sync #(.W(CNT_W), .LAT(SYNC_LAT)) u_sync (
                .clk        (clk),
                .rst_n      (rst_n),
                .wr_in      (sel_wr[gi]),
                .wdata_in   (bus_wdata),
                .apply      (apply[gi]),
                .apply_data (apply_data[gi]),
                .pending    (pend[gi])
            );
        end
    endgenerate

    logic unused_ctrl_hi;
    assign unused_ctrl_hi = ^apply_data[0][CNT_W-1:2];

    logic             ovf_clr;
    logic             run, reload, ovf;
    logic [CNT_W-1:0] load, count;

    assign ovf_clr = bus_wr && (bus_addr == A_STAT) && bus_wdata[0];

    tmr_count_core u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_apply  (apply[0]),
        .ctrl_run    (apply_data[0][0]),
        .ctrl_reload (apply_data[0][1]),
        .load_apply  (apply[1]),
        .load_val    (apply_data[1]),
        .cnt_apply   (apply[2]),
        .cnt_val     (apply_data[2]),
        .ovf_clr     (ovf_clr),
        .run         (run),
        .reload      (reload),
        .load        (load),
        .count       (count),
        .ovf         (ovf)
    );

    logic ie_d, ie_q;

    always_comb begin
        ie_d = ie_q;
        if (bus_wr && bus_addr == A_IEN) ie_d = bus_wdata[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ie_q <= 1'b0;
        else        ie_q <= ie_d;
    end

    assign irq = ovf & ie_q;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL:  bus_rdata[1:0]        = {reload, run};
            A_LOAD:  bus_rdata             = load;
            A_COUNT: bus_rdata             = count;
            A_STAT:  bus_rdata[0]          = ovf;
            A_IEN:   bus_rdata[0]          = ie_q;
            A_PEND:  bus_rdata[N_POST-1:0] = pend;
            default: bus_rdata             = '0;
        endcase
    end

    // R7: the interrupt line never rises while the enable is off
    assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ie_q);

    // R1: nothing is pending on the first cycle out of reset
    assert_reset_clean_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (pend == '0 && !irq));

endmodule

// File: tb/tmr_up_top_test.sv
module tmr_up_top_test;
    import tmr_pkg::*;

    localparam int L = 3;
    localparam logic [31:0] ONES = 32'hFFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    always #10 clk = ~clk;

    tmr_up_top #(.SYNC_LAT(L)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    int cyc = 0;
    int nchk = 0;
    int nerr = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct { int due; logic exp; string tag; } item_t;
    item_t sbq[$];

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: got %h expected %h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // drive at a falling edge; returns one cycle later, write captured on that edge
    task automatic bw(reg_addr_e a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(reg_addr_e a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic rchk(string tag, reg_addr_e a, logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic wait_until(int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic push(int due, logic exp, string tag);
        item_t it;
        it.due = due; it.exp = exp; it.tag = tag;
        sbq.push_back(it);
    endtask

    // monitor: compare queued irq expectations on their due cycle
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].due <= cyc) begin
            item_t it;
            it = sbq.pop_front();
            nchk++;
            if (it.due < cyc || irq !== it.exp) begin
                nerr++;
                $display("FAIL %s: irq got %b expected %b (due %0d, cycle %0d)",
                         it.tag, irq, it.exp, it.due, cyc);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        int c1, k1, k2, s, a, e;
        logic [31:0] lv;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rchk("R1 ctrl",  A_CTRL, 0);
        rchk("R1 load",  A_LOAD, 0);
        rchk("R1 count", A_COUNT, 0);
        rchk("R1 stat",  A_STAT, 0);
        rchk("R1 pend",  A_PEND, 0);
        chk("R1 irq", {31'b0, irq}, 0);

        // R8 posted reload write: pending bit 1 until applied L edges later
        bw(A_LOAD, 32'h1234);
        c1 = cyc;
        rchk("R8 pend load", A_PEND, 32'h2);
        rchk("R8 load old",  A_LOAD, 0);
        wait_until(c1 + L - 1);
        rchk("R8 load still old", A_LOAD, 0);
        rchk("R8 pend still",     A_PEND, 32'h2);
        wait_until(c1 + L);
        rchk("R8 load applied", A_LOAD, 32'h1234);
        rchk("R8 pend clear",   A_PEND, 0);

        // one-shot, N=4, interrupt disabled
        bw(A_COUNT, ONES - 4);
        k1 = cyc;
        bw(A_CTRL, 32'h1);
        k2 = cyc;
        s = k2 + L;
        rchk("R8 pend ctrl+count", A_PEND, 32'h5);
        wait_until(s + 2);
        rchk("R2 count advance", A_COUNT, ONES - 2);
        wait_until(s + 4);
        rchk("R3 no ovf yet", A_STAT, 0);
        wait_until(s + 5);
        rchk("R3 ovf set", A_STAT, 1);
        chk("R7 irq masked", {31'b0, irq}, 0);
        rchk("R4 count zero", A_COUNT, 0);
        rchk("R4 run cleared", A_CTRL, 0);
        wait_until(s + 8);
        rchk("R4 count stays", A_COUNT, 0);
        if (k1 + L > k2) ; // counter write applied before start

        // enable / clear
        bw(A_IEN, 32'h1);
        e = cyc;
        chk("R7 irq enabled", {31'b0, irq}, 1);
        bw(A_STAT, 32'h0);
        rchk("R6 write zero keeps", A_STAT, 1);
        bw(A_STAT, 32'h1);
        rchk("R6 write one clears", A_STAT, 0);
        chk("R7 irq follows", {31'b0, irq}, 0);
        if (e < 0) ;

        // periodic, P=5
        lv = ONES - 5;
        bw(A_LOAD, lv);
        bw(A_COUNT, lv);
        bw(A_CTRL, 32'h3);
        a = cyc;
        s = a + L;
        push(s + 5,  0, "R3 before first wrap");
        push(s + 6,  1, "R3 first wrap");
        push(s + 7,  0, "R6 cleared");
        push(s + 11, 0, "R5 before second wrap");
        push(s + 12, 1, "R5 second wrap");
        push(s + 13, 0, "R6 cleared again");
        push(s + 18, 1, "R6 set wins over clear");
        wait_until(s + 6);
        rchk("R5 reloaded", A_COUNT, lv);
        bw(A_STAT, 32'h1);
        wait_until(s + 12);
        bw(A_STAT, 32'h1);
        wait_until(s + 17);
        bw(A_STAT, 32'h1);
        rchk("R6 set wins stat", A_STAT, 1);

        // R9 stop: write at s+18, captured s+19, applied s+19+L
        bw(A_CTRL, 32'h0);
        wait_until(s + 19 + L);
        rchk("R9 count at stop", A_COUNT, lv + L + 1);
        rchk("R9 ctrl cleared",  A_CTRL, 0);
        wait_until(s + 23 + L);
        rchk("R9 count held", A_COUNT, lv + L + 1);
        bw(A_STAT, 32'h1);
        chk("R6 final clear irq", {31'b0, irq}, 0);

        repeat (4) @(negedge clk);
        chk("R3 scoreboard drained", sbq.size(), 0);
        summary();
    end

endmodule